// File: doc/BRIEF.md
# Two-Bank Cascaded Interrupt Controller

The block collects interrupt events into two 32-bit banks and drives one fast-interrupt level to the processor. Each bank keeps a pending register and an enable register. Hardware sources raise pending bits through per-bank request vectors. Software changes the registers through a word-wide register bus. Setting and clearing use separate addresses, so software never needs a read-modify-write to change one bit.

The second bank cascades into the first. The top bit of bank-0 pending is a summary: it is 1 whenever any bank-1 pending bit is 1, and the bank-1 enables have no effect on it. The interrupt output is registered. It goes active when either bank has a bit that is both pending and enabled. A bank-1 event can reach the processor in two ways: through its own enable, or through the summary bit and bank-0 enable bit 31.

Typical bank-0 sources are a software interrupt (bit 30), expansion DMA (bit 29), the audio DSP (bit 11), four timers (bits 10 down to 7) and two vertical-line events (bits 1 and 0). Typical bank-1 sources are disk insertion (bit 1) and player-bus DMA (bit 0).

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, every pending and enable register reads zero and `fastIrq` is low.
- R2: A write to byte address 0x40 ORs `busWrData` into bank-0 pending.
- R3: A write to 0x44 clears each bank-0 pending bit where `busWrData` is 1. Other bits are kept.
- R4: A write to 0x48 ORs `busWrData` into the bank-0 enable register. A write to 0x4C clears each enable bit where `busWrData` is 1.
- R5: Bank 1 behaves the same way at 0x60 (pending set), 0x64 (pending clear), 0x68 (enable set) and 0x6C (enable clear).
- R6: Bank-0 pending bit 31 equals the OR of all bank-1 pending bits in every cycle, whatever the bank-1 enables hold. A software write that sets or clears bank-0 bit 31 directly has no effect.
- R7: A 1 on any bit of `reqBank0` or `reqBank1` sets that bit of the bank's pending register on the next clock edge. The bit stays set after the request drops, until software clears it.
- R8: If a request and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: `fastIrq` is registered. One clock after the registers hold a pending-and-enabled bit in either bank, it is 1. One clock after no such bit remains, it is 0.
- R10: While `busRdEn` is 1, the set and clear addresses of a register both return that register on `busRdData` in the same cycle. An unmapped address returns zero, and `busRdData` is zero while `busRdEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (8) | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busWrData | input | DATA_W (32) | Write data used as a set or clear mask |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W (32) | Read data, combinational from address |
| reqBank0 | input | DATA_W (32) | Hardware requests into bank 0 |
| reqBank1 | input | DATA_W (32) | Hardware requests into bank 1 |
| fastIrq | output | 1 | Registered fast-interrupt level |

## Verification
A wrong pending or enable bit has one of two effects. It either drives `fastIrq` the wrong way one clock after it appears, or it stays hidden until it meets a matching bit in the other register. For that reason the bench reads the registers back through the bus after every stimulus step. It does not wait for the output alone. A broken cascade shows at once in a read of bank-0 pending, because bit 31 disagrees with the bank-1 contents. It shows a cycle later on `fastIrq` whenever bank-0 enable bit 31 is set. The reference model checks `fastIrq` on every clock, so a wrong latency, a lost request or a clear that wins over a request is caught within one cycle of the event.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  // Bank count; bank b summarises into the top bit of bank b-1.
  localparam int NUM_BANKS = 2;

  // Per-bank decoded strobes passed from the decoder to the register file.
  typedef struct packed {
    logic [NUM_BANKS-1:0] pendSet;
    logic [NUM_BANKS-1:0] pendClr;
    logic [NUM_BANKS-1:0] maskSet;
    logic [NUM_BANKS-1:0] maskClr;
    logic [NUM_BANKS-1:0] rdPend;
    logic [NUM_BANKS-1:0] rdMask;
  } regStrobe_t;

endpackage

// File: rtl/irq_cascade_decode.sv
module irq_cascade_decode
  import irq_cascade_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BANK0_BASE  = 'h40,
  parameter int BANK_STRIDE = 'h20
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobe_t        strb
);

  // Register offsets inside one bank window.
  localparam int OFS_PEND_SET = 'h0;
  localparam int OFS_PEND_CLR = 'h4;
  localparam int OFS_MASK_SET = 'h8;
  localparam int OFS_MASK_CLR = 'hC;

  logic [NUM_BANKS-1:0] pSet, pClr, mSet, mClr, rP, rM;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_PSET = ADDR_W'(BANK0_BASE + b*BANK_STRIDE + OFS_PEND_SET);
    localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(BANK0_BASE + b*BANK_STRIDE + OFS_PEND_CLR);
    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(BANK0_BASE + b*BANK_STRIDE + OFS_MASK_SET);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(BANK0_BASE + b*BANK_STRIDE + OFS_MASK_CLR);

    logic hitPSet, hitPClr, hitMSet, hitMClr;
    assign hitPSet = (busAddr == A_PSET);
    assign hitPClr = (busAddr == A_PCLR);
    assign hitMSet = (busAddr == A_MSET);
    assign hitMClr = (busAddr == A_MCLR);

    assign pSet[b] = busWrEn && hitPSet;
    assign pClr[b] = busWrEn && hitPClr;
    assign mSet[b] = busWrEn && hitMSet;
    assign mClr[b] = busWrEn && hitMClr;
    assign rP[b]   = busRdEn && (hitPSet || hitPClr);
    assign rM[b]   = busRdEn && (hitMSet || hitMClr);
  end

  assign strb = '{pendSet: pSet, pendClr: pClr, maskSet: mSet,
                  maskClr: mClr, rdPend: rP, rdMask: rM};

endmodule

// File: rtl/irq_cascade_regs.sv
module irq_cascade_regs
  import irq_cascade_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  regStrobe_t                       strb,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] reqIn,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] pendQ,
  output logic [NUM_BANKS-1:0][DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0]                rdData,
  output logic                             fastIrq
);

  localparam int SUM_BIT = DATA_W - 1;

  logic [NUM_BANKS-1:0][DATA_W-1:0] pendNext;
  logic [NUM_BANKS-1:0][DATA_W-1:0] maskNext;
  logic                             anyHit;

  // Walk banks top-down so each summary bit sees the final value of the bank above.
  always_comb begin
    pendNext = pendQ;
    maskNext = maskQ;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (strb.pendSet[b]) pendNext[b] = pendNext[b] | wrData;
      if (strb.pendClr[b]) pendNext[b] = pendNext[b] & ~wrData;
      // Requests are applied after the clear so an event is never dropped.
      pendNext[b] = pendNext[b] | reqIn[b];
      if (b < NUM_BANKS - 1) pendNext[b][SUM_BIT] = |pendNext[b+1];
      if (strb.maskSet[b]) maskNext[b] = maskNext[b] | wrData;
      if (strb.maskClr[b]) maskNext[b] = maskNext[b] & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
    end else begin
      pendQ <= pendNext;
      maskQ <= maskNext;
    end
  end

  always_comb begin
    anyHit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) anyHit = anyHit | (|(pendQ[b] & maskQ[b]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fastIrq <= 1'b0;
    else       fastIrq <= anyHit;
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.rdPend[b]) rdData = rdData | pendQ[b];
      if (strb.rdMask[b]) rdData = rdData | maskQ[b];
    end
  end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int BANK0_BASE  = 'h40,
  parameter int BANK_STRIDE = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] reqBank0,
  input  logic [DATA_W-1:0] reqBank1,
  output logic              fastIrq
);

  regStrobe_t                       strb;
  logic [NUM_BANKS-1:0][DATA_W-1:0] pendQ;
  logic [NUM_BANKS-1:0][DATA_W-1:0] maskQ;
  logic [NUM_BANKS-1:0][DATA_W-1:0] reqIn;
  logic [DATA_W-1:0]                pend0Q, pend1Q, mask0Q, mask1Q;

  assign reqIn  = {reqBank1, reqBank0};
  assign pend0Q = pendQ[0];
  assign pend1Q = pendQ[1];
  assign mask0Q = maskQ[0];
  assign mask1Q = maskQ[1];

  irq_cascade_decode #(
    .ADDR_W(ADDR_W), .BANK0_BASE(BANK0_BASE), .BANK_STRIDE(BANK_STRIDE)
  ) u_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strb(strb)
  );

  irq_cascade_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData), .reqIn(reqIn),
    .pendQ(pendQ), .maskQ(maskQ), .rdData(busRdData), .fastIrq(fastIrq)
  );

endmodule

// File: rtl/irq_cascade_checker.sv
module irq_cascade_checker #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int BANK0_BASE  = 'h40,
  parameter int BANK_STRIDE = 'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] reqBank0,
  input logic [DATA_W-1:0] reqBank1,
  input logic              fastIrq,
  input logic [DATA_W-1:0] pend0,
  input logic [DATA_W-1:0] pend1,
  input logic [DATA_W-1:0] mask0,
  input logic [DATA_W-1:0] mask1
);

  localparam int                TOP    = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_P0S  = ADDR_W'(BANK0_BASE);
  localparam logic [ADDR_W-1:0] A_P0C  = ADDR_W'(BANK0_BASE + 'h4);
  localparam logic [ADDR_W-1:0] A_M0S  = ADDR_W'(BANK0_BASE + 'h8);
  localparam logic [ADDR_W-1:0] A_M1C  = ADDR_W'(BANK0_BASE + BANK_STRIDE + 'hC);

  assert_summary_tracks_R6: assert property (@(posedge clk) disable iff (!rstN)
    pend0[TOP] == (|pend1));

  assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fastIrq == $past((|(pend0 & mask0)) || (|(pend1 & mask1))));

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_P0S) |=>
      ((pend0[TOP-1:0] & $past(busWrData[TOP-1:0])) == $past(busWrData[TOP-1:0])));

  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_P0C) |=>
      ((pend0[TOP-1:0] & $past(busWrData[TOP-1:0] & ~reqBank0[TOP-1:0])) == '0));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_M0S) |=> ((mask0 & $past(busWrData)) == $past(busWrData)));

  assert_mask1_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_M1C) |=> ((mask1 & $past(busWrData)) == '0));

  assert_request_lands_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqBank1 != '0) |=> ((pend1 & $past(reqBank1)) == $past(reqBank1)));

  assert_request_beats_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_P0C && reqBank0[TOP-1:0] != '0) |=>
      ((pend0[TOP-1:0] & $past(reqBank0[TOP-1:0])) == $past(reqBank0[TOP-1:0])));

endmodule

bind irq_cascade_ctrl irq_cascade_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK0_BASE(BANK0_BASE), .BANK_STRIDE(BANK_STRIDE)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .reqBank0(reqBank0), .reqBank1(reqBank1), .fastIrq(fastIrq),
  .pend0(pend0Q), .pend1(pend1Q), .mask0(mask0Q), .mask1(mask1Q)
);

// File: tb/irq_cascade_ctrl_test.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [31:0] reqBank0 = '0;
  logic [31:0] reqBank1 = '0;
  logic        fastIrq;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  irq_cascade_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .reqBank0(reqBank0), .reqBank1(reqBank1),
    .fastIrq(fastIrq)
  );

  // Behavioural reference: register images indexed by bank.
  logic [31:0] mPend [2];
  logic [31:0] mMask [2];
  logic        mIrq = 1'b0;
  initial begin mPend = '{0, 0}; mMask = '{0, 0}; end

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '{0, 0}; mMask = '{0, 0}; mIrq = 1'b0;
    end else begin
      logic [31:0] np [2];
      logic [31:0] nm [2];
      mIrq = ((mPend[0] & mMask[0]) != 0) || ((mPend[1] & mMask[1]) != 0);
      for (int b = 0; b < 2; b++) begin
        int base;
        base = 'h40 + 'h20 * b;
        np[b] = mPend[b];
        nm[b] = mMask[b];
        if (busWrEn && busAddr == base)       np[b] = np[b] | busWrData;
        if (busWrEn && busAddr == base + 4)   np[b] = np[b] & ~busWrData;
        if (busWrEn && busAddr == base + 8)   nm[b] = nm[b] | busWrData;
        if (busWrEn && busAddr == base + 12)  nm[b] = nm[b] & ~busWrData;
      end
      np[0] = np[0] | reqBank0;
      np[1] = np[1] | reqBank1;
      np[0][31] = (np[1] != 0);
      mPend = np;
      mMask = nm;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // R9: output compared against the model on every clock.
  always @(posedge clk) begin
    #1;
    if (!done) check("R9 per-cycle fastIrq", {31'd0, fastIrq}, {31'd0, mIrq});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    check(tag, busRdData, exp);
    busRdEn = 1'b0;
  endtask

  task automatic irqIs(logic exp, string tag);
    check(tag, {31'd0, fastIrq}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'h40, 32'h0, "R1 pend0 reset");
    rd(8'h48, 32'h0, "R1 mask0 reset");
    rd(8'h60, 32'h0, "R1 pend1 reset");
    rd(8'h68, 32'h0, "R1 mask1 reset");
    irqIs(1'b0, "R1 fastIrq reset");

    wr(8'h40, 32'h0000_0401);
    rd(8'h40, 32'h0000_0401, "R2 pend0 set");
    rd(8'h44, 32'h0000_0401, "R10 read via clear address");
    irqIs(1'b0, "R9 masked pending gives no irq");

    wr(8'h48, 32'h0000_0400);
    irqIs(1'b0, "R9 one-cycle latency");
    @(negedge clk);
    irqIs(1'b1, "R9 irq after enable");
    rd(8'h4C, 32'h0000_0400, "R4 mask0 set");

    wr(8'h44, 32'h0000_0400);
    rd(8'h40, 32'h0000_0001, "R3 pend0 clear");
    @(negedge clk);
    irqIs(1'b0, "R9 irq drops after clear");
    wr(8'h4C, 32'h0000_0400);
    rd(8'h48, 32'h0, "R4 mask0 clear");

    wr(8'h60, 32'h0000_0002);
    rd(8'h60, 32'h0000_0002, "R5 pend1 set");
    rd(8'h40, 32'h8000_0001, "R6 summary set by bank1");
    @(negedge clk);
    irqIs(1'b0, "R6 summary with no enables");

    wr(8'h48, 32'h8000_0000);
    @(negedge clk);
    irqIs(1'b1, "R6 cascade through mask0 bit31");
    wr(8'h44, 32'h8000_0000);
    rd(8'h40, 32'h8000_0001, "R6 direct clear of bit31 ignored");

    wr(8'h64, 32'h0000_0002);
    rd(8'h60, 32'h0, "R5 pend1 clear");
    rd(8'h40, 32'h0000_0001, "R6 summary follows bank1 clear");
    wr(8'h40, 32'h8000_0000);
    rd(8'h40, 32'h0000_0001, "R6 direct set of bit31 ignored");
    @(negedge clk);
    irqIs(1'b0, "R9 irq low with empty bank1");

    @(negedge clk); reqBank0 = 32'h0000_0080;
    @(negedge clk); reqBank0 = '0;
    repeat (2) @(negedge clk);
    rd(8'h40, 32'h0000_0081, "R7 bank0 request sticky");
    @(negedge clk); reqBank1 = 32'h0000_0001;
    @(negedge clk); reqBank1 = '0;
    rd(8'h60, 32'h0000_0001, "R7 bank1 request sticky");
    rd(8'h40, 32'h8000_0081, "R7 bank1 request raises summary");
    @(negedge clk);
    irqIs(1'b1, "R9 irq via cascaded request");
    wr(8'h4C, 32'h8000_0000);
    @(negedge clk);
    irqIs(1'b0, "R4 irq off after mask clear");

    @(negedge clk);
    busAddr = 8'h44; busWrEn = 1'b1; busWrData = 32'h0000_0281; reqBank0 = 32'h0000_0200;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0; reqBank0 = '0;
    rd(8'h40, 32'h8000_0200, "R8 request beats clear");

    wr(8'h68, 32'h0000_0001);
    rd(8'h6C, 32'h0000_0001, "R5 mask1 set");
    @(negedge clk);
    irqIs(1'b1, "R5 irq via bank1 enable");
    wr(8'h6C, 32'h0000_0001);
    rd(8'h68, 32'h0, "R5 mask1 clear");
    @(negedge clk);
    irqIs(1'b0, "R5 irq off after mask1 clear");

    rd(8'h50, 32'h0, "R10 unmapped read zero");
    @(negedge clk);
    busAddr = 8'h40; busRdEn = 1'b0;
    #1;
    check("R10 read data zero without strobe", busRdData, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule